// File: doc/BRIEF.md
# Paged memory window translator

This block lets a CPU reach a physical memory larger than its address window by splitting each window into eight 16 KB slots. Every slot has a page register that supplies the upper physical address bits. Software programs the page registers through I/O writes. Each register holds an enable flag and seven physical address bits, A20 down to A14. The block watches every memory address. When the address falls in an enabled slot, it swaps the slot's upper bits for the page register bits and raises a hit flag. Otherwise the address passes through unchanged.

There are two windows, and both use the same eight page registers. Window A sits at a 128 KB-aligned base given on an input. Window B is hardwired to start at 0A0000h. The I/O ports of the page registers start at one of seven bases picked by a 4-bit select code. The ports of successive pages lie 2000h apart in I/O space. Extension setup and the two window enables come from elsewhere as plain level inputs.

The block is fully combinational from the inputs and the register contents to its outputs. Only the page register file is clocked.

Top module: `paged_win_xlat`

## Requirements
- R1: After reset every page register reads 00h, so every page is disabled and no address is translated.
- R2: A write to the port of page n stores all 8 bits. The port of page n is the decoded base plus n×2000h, with n taken from I/O address bits 15:13. A read of the same port raises `io_ack` and returns the stored byte on `io_rdata` in the cycle the read strobe is high.
- R3: The select code sets the decoded base within each 2000h stride: 0000→208h, 0001→218h, 0101→258h, 0110→268h, 1010→2A8h, 1011→2B8h, 1110→2E8h.
- R4: Any other select code decodes no port. Writes leave every register unchanged, and reads give `io_ack`=0 with `io_rdata`=00h.
- R5: An I/O address whose bits 12:0 differ from the decoded base is not claimed. A write to it changes no register. A read of it gives `io_ack`=0 and `io_rdata`=00h.
- R6: An address whose bits 23:17 equal `win_a_base` falls in window A, slot = bits 16:14. If that page is live, `phys_addr` = {000b, page bits 6:0, address bits 13:0} and `xlat_hit`=1. A page is live when its bit 7 is set and the gating of R8 is open.
- R7: Addresses 0A0000h–0BFFFFh fall in window B, with the slot taken from bits 16:14. Window B translates the same way as R6, whatever `win_a_base` holds (except as stated in R10).
- R8: Translation needs `ext_cfg_ok`=1 and the enable of the window that was hit (`win_a_en` or `win_b_en`). If either is low, the address passes through and `xlat_hit` is 0.
- R9: When the slot's page has bit 7 clear, or the address lies in neither window, `phys_addr` equals `mem_addr` and `xlat_hit`=0.
- R10: When `win_a_base` equals 5 (window A placed over window B), window A's enable alone decides; `win_b_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_code | input | 4 | I/O base select code |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 00h when not claimed |
| io_ack | output | 1 | Read claimed by a page port |
| ext_cfg_ok | input | 1 | Extension registers configured |
| win_a_en | input | 1 | Window A enable |
| win_b_en | input | 1 | Window B enable |
| win_a_base | input | 7 | Window A base, address bits 23:17 |
| mem_addr | input | 24 | Incoming memory address |
| phys_addr | output | 24 | Translated or passed-through address |
| xlat_hit | output | 1 | Address was translated |

## Verification
The hardest case to reach from the ports is a page register that must stay unchanged after a write that should not land. This happens with an unlisted select code or an address that almost matches a port. Such a write is only visible later, through a claimed read or a translation. The stimulus first fills pages with known values. It then fires writes under unlisted codes and at near-miss addresses. Finally it switches back to a valid code and reads every page and translates through it. A reference model running every cycle flags any stray update the moment it shows.

// File: rtl/paged_win_pkg.sv
package paged_win_pkg;

    // Low 13 bits of the page 0 port for a select code.
    // The valid codes are exactly those listed in the requirements.
    function automatic logic sel_code_valid(input logic [3:0] code);
        logic ok;
        unique case (code)
            4'b0000, 4'b0001, 4'b0101, 4'b0110,
            4'b1010, 4'b1011, 4'b1110: ok = 1'b1;
            default:                   ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Base = 208h with the code placed in bits 7:4.
    function automatic logic [12:0] sel_code_base(input logic [3:0] code);
        return 13'h208 | {5'd0, code, 4'd0};
    endfunction

endpackage

// File: rtl/pw_io_decode.sv
module pw_io_decode
    import paged_win_pkg::*;
#(
    parameter int IO_W   = 16,
    parameter int NPAGE  = 8,
    localparam int IDX_W = $clog2(NPAGE),
    localparam int STR_W = IO_W - IDX_W
) (
    input  logic [3:0]       sel_code,
    input  logic [IO_W-1:0]  io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    output logic             wr_en,
    output logic             rd_en,
    output logic [IDX_W-1:0] port_idx
);
    logic            code_ok;
    logic [STR_W-1:0] base_lo;
    logic            claim;

    always_comb begin
        code_ok  = sel_code_valid(sel_code);
        base_lo  = STR_W'(sel_code_base(sel_code));
        claim    = code_ok && (io_addr[STR_W-1:0] == base_lo);
        port_idx = io_addr[IO_W-1:STR_W];
        wr_en    = claim && io_wr;
        rd_en    = claim && io_rd;
    end
endmodule

// File: rtl/pw_page_regs.sv
module pw_page_regs #(
    parameter int NPAGE  = 8,
    parameter int REG_W  = 8,
    localparam int IDX_W = $clog2(NPAGE)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [REG_W-1:0]             wdata,
    output logic [REG_W-1:0]             rdata,
    output logic [NPAGE-1:0][REG_W-1:0]  pages
);
    for (genvar g = 0; g < NPAGE; g++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pages[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g))) begin
                pages[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = rd_en ? pages[idx] : '0;
    end
endmodule

// File: rtl/pw_win_xlate.sv
module pw_win_xlate #(
    parameter int            ADDR_W     = 24,
    parameter int            NPAGE      = 8,
    parameter int            REG_W      = 8,
    parameter int            PAGE_W     = 14,
    parameter logic [23:0]   WIN_B_BASE = 24'h0A0000,
    localparam int IDX_W   = $clog2(NPAGE),
    localparam int WIN_LSB = PAGE_W + IDX_W,
    localparam int TAG_W   = ADDR_W - WIN_LSB,
    localparam int XL_W    = REG_W - 1,
    localparam int PAD_W   = ADDR_W - XL_W - PAGE_W
) (
    input  logic [NPAGE-1:0][REG_W-1:0] pages,
    input  logic                        ext_cfg_ok,
    input  logic                        win_a_en,
    input  logic                        win_b_en,
    input  logic [TAG_W-1:0]            win_a_base,
    input  logic [ADDR_W-1:0]           mem_addr,
    output logic [ADDR_W-1:0]           phys_addr,
    output logic                        xlat_hit
);
    localparam logic [TAG_W-1:0] B_TAG = WIN_B_BASE[ADDR_W-1:WIN_LSB];

    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] slot;
    logic             in_a, in_b, win_open;
    logic [REG_W-1:0] cur;

    always_comb begin
        tag  = mem_addr[ADDR_W-1:WIN_LSB];
        slot = mem_addr[WIN_LSB-1:PAGE_W];
        in_a = (tag == win_a_base);
        in_b = (tag == B_TAG);
        // Window A wins when both claim the address.
        if (in_a)      win_open = win_a_en;
        else if (in_b) win_open = win_b_en;
        else           win_open = 1'b0;
        cur      = pages[slot];
        xlat_hit = win_open && ext_cfg_ok && cur[REG_W-1];
        phys_addr = xlat_hit ? {{PAD_W{1'b0}}, cur[XL_W-1:0], mem_addr[PAGE_W-1:0]}
                             : mem_addr;
    end
endmodule

// File: rtl/paged_win_xlat.sv
module paged_win_xlat #(
    parameter int          ADDR_W     = 24,
    parameter int          IO_W       = 16,
    parameter int          NPAGE      = 8,
    parameter int          REG_W      = 8,
    parameter int          PAGE_W     = 14,
    parameter logic [23:0] WIN_B_BASE = 24'h0A0000,
    localparam int IDX_W = $clog2(NPAGE),
    localparam int TAG_W = ADDR_W - PAGE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        sel_code,
    input  logic [IO_W-1:0]   io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    output logic              io_ack,
    input  logic              ext_cfg_ok,
    input  logic              win_a_en,
    input  logic              win_b_en,
    input  logic [TAG_W-1:0]  win_a_base,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              xlat_hit
);
    logic                        dec_wr_en, dec_rd_en;
    logic [IDX_W-1:0]            dec_idx;
    logic [NPAGE-1:0][REG_W-1:0] page_q;

    pw_io_decode #(.IO_W(IO_W), .NPAGE(NPAGE)) i_dec (
        .sel_code (sel_code),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .wr_en    (dec_wr_en),
        .rd_en    (dec_rd_en),
        .port_idx (dec_idx)
    );

    pw_page_regs #(.NPAGE(NPAGE), .REG_W(REG_W)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dec_wr_en),
        .rd_en (dec_rd_en),
        .idx   (dec_idx),
        .wdata (io_wdata),
        .rdata (io_rdata),
        .pages (page_q)
    );

    assign io_ack = dec_rd_en;

    pw_win_xlate #(
        .ADDR_W(ADDR_W), .NPAGE(NPAGE), .REG_W(REG_W),
        .PAGE_W(PAGE_W), .WIN_B_BASE(WIN_B_BASE)
    ) i_xl (
        .pages      (page_q),
        .ext_cfg_ok (ext_cfg_ok),
        .win_a_en   (win_a_en),
        .win_b_en   (win_b_en),
        .win_a_base (win_a_base),
        .mem_addr   (mem_addr),
        .phys_addr  (phys_addr),
        .xlat_hit   (xlat_hit)
    );
endmodule

// File: rtl/paged_win_xlat_chk.sv
module paged_win_xlat_chk #(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 16,
    parameter int REG_W  = 8,
    parameter int PAGE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        sel_code,
    input logic [IO_W-1:0]   io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [REG_W-1:0]  io_wdata,
    input logic [REG_W-1:0]  io_rdata,
    input logic              io_ack,
    input logic              dec_wr_en,
    input logic              ext_cfg_ok,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              xlat_hit
);
    logic code_listed;
    always_comb begin
        code_listed = (sel_code == 4'b0000) || (sel_code == 4'b0001) ||
                      (sel_code == 4'b0101) || (sel_code == 4'b0110) ||
                      (sel_code == 4'b1010) || (sel_code == 4'b1011) ||
                      (sel_code == 4'b1110);
    end

    // R2: a write to a claimed port is read back on the next cycle
    a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dec_wr_en) && io_ack &&
         io_addr == $past(io_addr) && $stable(sel_code))
        |-> io_rdata == $past(io_wdata));

    // R4: an unlisted code never acknowledges
    a_r4_bad_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !code_listed |-> (!io_ack && io_rdata == '0));

    // R5: unclaimed reads return zero
    a_r5_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ack |-> io_rdata == '0);

    // R6: a hit keeps the in-page offset and clears bits above A20
    a_r6_hit_offset: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_hit |-> (phys_addr[PAGE_W-1:0] == mem_addr[PAGE_W-1:0] &&
                      phys_addr[ADDR_W-1:PAGE_W+REG_W-1] == '0));

    // R8: no translation without the extension flag
    a_r8_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_cfg_ok |-> !xlat_hit);

    // R9: a miss passes the address through
    a_r9_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_hit |-> phys_addr == mem_addr);
endmodule

bind paged_win_xlat paged_win_xlat_chk #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .REG_W(REG_W), .PAGE_W(PAGE_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_code   (sel_code),
    .io_addr    (io_addr),
    .io_wr      (io_wr),
    .io_rd      (io_rd),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_ack     (io_ack),
    .dec_wr_en  (dec_wr_en),
    .ext_cfg_ok (ext_cfg_ok),
    .mem_addr   (mem_addr),
    .phys_addr  (phys_addr),
    .xlat_hit   (xlat_hit)
);

// File: tb/test_paged_win_xlat.sv
module test_paged_win_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel_code = 4'b0000;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_ack;
    logic        ext_cfg_ok = 1'b0, win_a_en = 1'b0, win_b_en = 1'b0;
    logic [6:0]  win_a_base = '0;
    logic [23:0] mem_addr = '0;
    logic [23:0] phys_addr;
    logic        xlat_hit;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] mdl [8];

    always #5 clk = ~clk;

    paged_win_xlat i_paged_win_xlat (.*);

    function automatic int base_of(input logic [3:0] c);
        case (c)
            4'b0000: return 'h208;
            4'b0001: return 'h218;
            4'b0101: return 'h258;
            4'b0110: return 'h268;
            4'b1010: return 'h2A8;
            4'b1011: return 'h2B8;
            4'b1110: return 'h2E8;
            default: return -1;
        endcase
    endfunction

    function automatic bit claimed();
        int b = base_of(sel_code);
        return (b >= 0) && (int'(io_addr[12:0]) == b);
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model, then take one clock edge.
    task automatic cyc(input string tag);
        bit e_ack, e_hit, in_a, in_b, wopen;
        logic [7:0]  e_rd, pg;
        logic [23:0] e_phys;
        int slot;
        #1;
        e_ack = io_rd && claimed();
        e_rd  = e_ack ? mdl[io_addr[15:13]] : 8'h00;
        slot  = int'(mem_addr[16:14]);
        pg    = mdl[slot];
        in_a  = (mem_addr[23:17] == win_a_base);
        in_b  = (mem_addr >= 24'h0A0000) && (mem_addr <= 24'h0BFFFF);
        wopen = in_a ? win_a_en : (in_b ? win_b_en : 1'b0);
        e_hit = wopen && ext_cfg_ok && pg[7];
        e_phys = e_hit ? ((24'(pg[6:0]) << 14) + 24'(mem_addr[13:0])) : mem_addr;
        chk(tag, "io_ack", io_ack, e_ack);
        chk(tag, "io_rdata", io_rdata, e_rd);
        chk(tag, "xlat_hit", xlat_hit, e_hit);
        chk(tag, "phys_addr", phys_addr, e_phys);
        @(posedge clk);
        if (rst_n && io_wr && claimed()) mdl[io_addr[15:13]] = io_wdata;
        @(negedge clk);
    endtask

    task automatic io_write(input string tag, input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        cyc(tag);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input string tag, input logic [15:0] a);
        io_addr = a; io_rd = 1'b1;
        cyc(tag);
        io_rd = 1'b0;
    endtask

    task automatic mem(input string tag, input logic [23:0] a);
        mem_addr = a;
        cyc(tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        @(negedge clk);
        io_read("R1", 16'h0208);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all pages read zero after reset
        for (int p = 0; p < 8; p++) io_read("R1", 16'(p * 'h2000 + 'h208));
        ext_cfg_ok = 1'b1; win_a_en = 1'b1; win_b_en = 1'b1; win_a_base = 7'h10;
        mem("R1", 24'h200000 + 24'h4123);

        // R2/R3: every listed code, every page
        foreach (sel_code_list[k]) begin
            sel_code = sel_code_list[k];
            for (int p = 0; p < 8; p++) begin
                io_write("R3", 16'(p * 'h2000 + base_of(sel_code)), 8'(k * 16 + p + 8'h81));
                io_read("R2", 16'(p * 'h2000 + base_of(sel_code)));
            end
        end
        sel_code = 4'b0000;
        for (int p = 0; p < 8; p++) io_write("R2", 16'(p * 'h2000 + 'h208), 8'h80 | 8'(p * 9 + 3));

        // R4: unlisted codes claim nothing
        for (int c = 0; c < 16; c++) begin
            sel_code = 4'(c);
            if (base_of(sel_code) < 0) begin
                io_write("R4", 16'h2208 | 16'(c << 4), 8'h00);
                io_read("R4", 16'h2208 | 16'(c << 4));
                io_read("R4", 16'h0208);
            end
        end
        sel_code = 4'b0000;
        // R5: near-miss ports
        io_write("R5", 16'h0209, 8'h00);
        io_write("R5", 16'h1208, 8'h00);
        io_write("R5", 16'h2218, 8'h00);
        io_read("R5", 16'h4248);
        for (int p = 0; p < 8; p++) io_read("R4", 16'(p * 'h2000 + 'h208));

        // R6: window A at 200000h
        for (int p = 0; p < 8; p++) mem("R6", 24'h200000 + 24'(p * 'h4000) + 24'h1ABC);
        mem("R9", 24'h1FFFFF);
        mem("R9", 24'h220000);
        // R7: window B
        for (int p = 0; p < 8; p++) mem("R7", 24'h0A0000 + 24'(p * 'h4000) + 24'h3FFF);
        mem("R9", 24'h09FFFF);
        mem("R9", 24'h0C0000);
        // R8: gating
        ext_cfg_ok = 1'b0; mem("R8", 24'h204000); mem("R8", 24'h0A4000);
        ext_cfg_ok = 1'b1; win_a_en = 1'b0; mem("R8", 24'h204000); mem("R8", 24'h0A4000);
        win_a_en = 1'b1; win_b_en = 1'b0; mem("R8", 24'h204000); mem("R8", 24'h0A4000);
        win_b_en = 1'b1;
        // R9: disabled page
        io_write("R9", 16'h6208, 8'h15);
        mem("R9", 24'h20C010);
        mem("R9", 24'h0AC010);
        // R10: window A placed over window B
        win_a_base = 7'h05;
        mem("R10", 24'h0A8000);
        win_a_en = 1'b0; mem("R10", 24'h0A8000);
        win_a_en = 1'b1; win_b_en = 1'b0; mem("R10", 24'h0A8000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    logic [3:0] sel_code_list [7] = '{4'b0000, 4'b0001, 4'b0101, 4'b0110,
                                      4'b1010, 4'b1011, 4'b1110};
endmodule